// File: doc/BRIEF.md
# Double-Buffered Input Gamma Lookup

This block is the input gamma stage of a display pixel pipeline. Each of the red, green and blue 8-bit pixel components goes through a 256-entry table. The table returns a 12-bit unsigned fraction (u0.12, no integer bits). Two complete table banks are held. The pixel path reads the live bank while a host loads the other bank through a small register port. A mode switch then makes the newly loaded bank live at the next frame boundary, so a table update never tears the displayed image.

The host port is a plain valid/address/data write interface. One control register holds the lookup mode, the bank the host writes, a per-channel write mask and a memory enable. An index register sets the write position. A single colour data register takes the values for one index in the order red, green, blue, and then steps to the next index by itself.

A small state machine tracks the colour phase, with the states `PH_RED`, `PH_GRN` and `PH_BLU`:
- `PH_RED` moves to `PH_GRN` on an accepted data write.
- `PH_GRN` moves to `PH_BLU` on an accepted data write.
- `PH_BLU` moves to `PH_RED` on an accepted data write, and the index increments.
- Any index write returns the machine to `PH_RED`.

A second state machine holds the live lookup, with the states `LIVE_BYP`, `LIVE_A` and `LIVE_B`:
- On a frame-start pulse it moves to `LIVE_A` when the requested mode is 2.
- On a frame-start pulse it moves to `LIVE_B` when the requested mode is 3.
- On a frame-start pulse it moves to `LIVE_BYP` for any other requested mode.
- Between frame-start pulses it holds its state.

Top module: `igam_lut_top`

## Requirements
- R1: During and after reset, `out_valid` is 0 and `live_status` is 0, meaning bypass.
- R2: While the live lookup is bypass, each output channel is the 8-bit input x widened to 12 bits as {x, x[7:4]}. The output appears one clock after the input, and `out_valid` is `pix_valid` delayed by one clock.
- R3: While bank A or bank B is live, each output channel is the stored value of that channel at the index equal to that channel's own input. The latency is the same one clock as in R2.
- R4: Host register map, with `host_addr` selecting the register:
  - Address 0 is control: bits [1:0] are the mode request, bit 2 is the bank written, bits [5:3] are the write mask, and bit 6 is the memory enable.
  - Address 1 is the index, taken from bits [7:0].
  - Address 2 is colour data, taken from bits [11:0].
  - Address 3 has no effect.
- R5: Accepted data writes go to red, then green, then blue of the current index. After the blue write the index increments, and it wraps from 255 to 0.
- R6: Mask bit 0 enables red, bit 1 enables green and bit 2 enables blue. A data write to a masked-off channel leaves that entry unchanged, but the phase still advances.
- R7: An index write sets the write position and returns the phase to red, even partway through a triplet.
- R8: Control bit 2 selects the bank written: 0 is bank A and 1 is bank B. Writes never change the other bank, and writing the idle bank leaves the live output undisturbed.
- R9: A mode request of 2 selects bank A, 3 selects bank B, and 0 or 1 selects bypass. A new request takes effect only on a `frame_start` pulse, and both the output mapping and `live_status` keep the old state until then.
- R10: `live_status` is 1 while bank A is live, 2 while bank B is live, and 0 in bypass. No other value occurs.
- R11: Data writes made while the memory enable (control bit 6) is 0 are ignored. They change no entry, no phase and no index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_valid | input | 1 | Host write strobe |
| host_addr | input | 2 | Register select |
| host_wdata | input | 12 | Host write data |
| frame_start | input | 1 | Frame boundary pulse; applies the requested mode |
| pix_valid | input | 1 | Input pixel valid |
| pix_r | input | 8 | Red input |
| pix_g | input | 8 | Green input |
| pix_b | input | 8 | Blue input |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 12 | Red result, u0.12 |
| out_g | output | 12 | Green result, u0.12 |
| out_b | output | 12 | Blue result, u0.12 |
| live_status | output | 3 | Live lookup: 0 bypass, 1 bank A, 2 bank B |

## Verification
The bench sweeps all 256 codes in bypass and through both fully programmed banks, giving each channel a different index so that a crossed channel or a one-off index shows up. It aims at the cases where the sequencer is easiest to get wrong:
- A masked channel that is written, which would skew every later entry if the phase stalled.
- An index rewrite partway through a triplet, which would drop values into the wrong colour if the phase were not cleared.
- The wrap from index 255 to 0.
- Data writes with the memory disabled, which would corrupt entries or shift the write position.

It also confirms that a mode request waits for the frame pulse, and that loading the idle bank leaves the live bank's output intact.

// File: rtl/igam_pkg.sv
package igam_pkg;
    typedef enum logic [1:0] {PH_RED = 2'd0, PH_GRN = 2'd1, PH_BLU = 2'd2} phase_e;
    typedef enum logic [1:0] {LIVE_BYP = 2'd0, LIVE_A = 2'd1, LIVE_B = 2'd2} live_e;

    localparam logic [1:0] REG_CTRL  = 2'd0;
    localparam logic [1:0] REG_INDEX = 2'd1;
    localparam logic [1:0] REG_DATA  = 2'd2;

    localparam int NUM_CH   = 3;
    localparam int NUM_BANK = 2;
endpackage

// File: rtl/igam_host_seq.sv
module igam_host_seq
    import igam_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int VAL_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic [1:0]        host_addr,
    input  logic [VAL_W-1:0]  host_wdata,
    output logic [1:0]        mode_req,
    output logic              wr_bank,
    output logic              pwr_en,
    output logic [NUM_CH-1:0] chan_we,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [VAL_W-1:0]  wr_val,
    output phase_e            wr_phase
);
    localparam int CTRL_W = 7;

    logic [CTRL_W-1:0] ctrl_q;
    phase_e            phase_q, phase_nx;
    logic [IDX_W-1:0]  idx_q, idx_nx;
    logic              data_wr, idx_wr, ctrl_wr;
    logic [NUM_CH-1:0] phase_sel;

    assign ctrl_wr = host_valid && (host_addr == REG_CTRL);
    assign idx_wr  = host_valid && (host_addr == REG_INDEX);
    assign data_wr = host_valid && (host_addr == REG_DATA) && ctrl_q[6];

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_RED;
            idx_q   <= '0;
            ctrl_q  <= '0;
        end else begin
            phase_q <= phase_nx;
            idx_q   <= idx_nx;
            if (ctrl_wr) ctrl_q <= host_wdata[CTRL_W-1:0];
        end
    end

    // Next-state logic: colour phase and auto-incrementing index
    always_comb begin
        phase_nx = phase_q;
        idx_nx   = idx_q;
        if (idx_wr) begin
            idx_nx   = host_wdata[IDX_W-1:0];
            phase_nx = PH_RED;
        end else if (data_wr) begin
            unique case (phase_q)
                PH_RED:  phase_nx = PH_GRN;
                PH_GRN:  phase_nx = PH_BLU;
                PH_BLU: begin
                    phase_nx = PH_RED;
                    idx_nx   = idx_q + 1'b1;
                end
                default: phase_nx = PH_RED;
            endcase
        end
    end

    // Output process
    always_comb begin
        unique case (phase_q)
            PH_RED:  phase_sel = 3'b001;
            PH_GRN:  phase_sel = 3'b010;
            PH_BLU:  phase_sel = 3'b100;
            default: phase_sel = 3'b000;
        endcase
        chan_we = data_wr ? (phase_sel & ctrl_q[5:3]) : '0;
    end

    assign mode_req = ctrl_q[1:0];
    assign wr_bank  = ctrl_q[2];
    assign pwr_en   = ctrl_q[6];
    assign wr_idx   = idx_q;
    assign wr_val   = host_wdata;
    assign wr_phase = phase_q;
endmodule

// File: rtl/igam_bank.sv
module igam_bank #(
    parameter int IDX_W = 8,
    parameter int VAL_W = 12,
    parameter int CH    = 3
) (
    input  logic                clk,
    input  logic [CH-1:0]       we,
    input  logic [IDX_W-1:0]    waddr,
    input  logic [VAL_W-1:0]    wdata,
    input  logic [CH*IDX_W-1:0] raddr,
    output logic [CH*VAL_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    for (genvar c = 0; c < CH; c++) begin : g_ch
        logic [VAL_W-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (we[c]) mem[waddr] <= wdata;
            rdata[c*VAL_W +: VAL_W] <= mem[raddr[c*IDX_W +: IDX_W]];
        end
    end
endmodule

// File: rtl/igam_live_ctrl.sv
module igam_live_ctrl
    import igam_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic [1:0] mode_req,
    output live_e      live,
    output logic [2:0] status
);
    live_e live_q, live_nx;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= LIVE_BYP;
        else        live_q <= live_nx;
    end

    always_comb begin
        live_nx = live_q;
        if (frame_start) begin
            unique case (mode_req)
                2'd2:    live_nx = LIVE_A;
                2'd3:    live_nx = LIVE_B;
                default: live_nx = LIVE_BYP;
            endcase
        end
    end

    // Output process
    always_comb begin
        unique case (live_q)
            LIVE_A:  status = 3'd1;
            LIVE_B:  status = 3'd2;
            default: status = 3'd0;
        endcase
    end

    assign live = live_q;
endmodule

// File: rtl/igam_pix_path.sv
module igam_pix_path
    import igam_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int VAL_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pix_valid,
    input  logic [NUM_CH*IDX_W-1:0] pix_in,
    input  live_e                   live,
    input  logic [NUM_CH*VAL_W-1:0] rdata_a,
    input  logic [NUM_CH*VAL_W-1:0] rdata_b,
    output logic                    out_valid,
    output logic [NUM_CH*VAL_W-1:0] out_px
);
    // Widening replicates the top input bits; requires VAL_W - IDX_W <= IDX_W.
    localparam int EXT_W = VAL_W - IDX_W;

    logic [NUM_CH*VAL_W-1:0] byp_nx, byp_q;
    live_e                   live_q;
    logic                    valid_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_widen
        assign byp_nx[c*VAL_W +: VAL_W] =
            {pix_in[c*IDX_W +: IDX_W], pix_in[c*IDX_W + IDX_W - 1 -: EXT_W]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            live_q  <= LIVE_BYP;
            byp_q   <= '0;
        end else begin
            valid_q <= pix_valid;
            live_q  <= live;
            byp_q   <= byp_nx;
        end
    end

    always_comb begin
        unique case (live_q)
            LIVE_A:  out_px = rdata_a;
            LIVE_B:  out_px = rdata_b;
            default: out_px = byp_q;
        endcase
    end

    assign out_valid = valid_q;
endmodule

// File: rtl/igam_lut_top.sv
module igam_lut_top
    import igam_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int VAL_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_valid,
    input  logic [1:0]       host_addr,
    input  logic [VAL_W-1:0] host_wdata,
    input  logic             frame_start,
    input  logic             pix_valid,
    input  logic [IDX_W-1:0] pix_r,
    input  logic [IDX_W-1:0] pix_g,
    input  logic [IDX_W-1:0] pix_b,
    output logic             out_valid,
    output logic [VAL_W-1:0] out_r,
    output logic [VAL_W-1:0] out_g,
    output logic [VAL_W-1:0] out_b,
    output logic [2:0]       live_status
);
    logic [1:0]              mode_req;
    logic                    wr_bank;
    logic                    pwr_en;
    logic [NUM_CH-1:0]       chan_we;
    logic [IDX_W-1:0]        wr_idx;
    logic [VAL_W-1:0]        wr_val;
    phase_e                  wr_phase;
    live_e                   live;
    logic [NUM_CH*IDX_W-1:0] pix_in;
    logic [NUM_CH*VAL_W-1:0] rdata [NUM_BANK];
    logic [NUM_CH*VAL_W-1:0] out_px;

    assign pix_in = {pix_b, pix_g, pix_r};

    igam_host_seq #(.IDX_W(IDX_W), .VAL_W(VAL_W)) host_i (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_addr(host_addr),
        .host_wdata(host_wdata), .mode_req(mode_req), .wr_bank(wr_bank),
        .pwr_en(pwr_en), .chan_we(chan_we), .wr_idx(wr_idx), .wr_val(wr_val),
        .wr_phase(wr_phase)
    );

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        logic [NUM_CH-1:0] bank_we;
        assign bank_we = (wr_bank == b[0]) ? chan_we : '0;
        igam_bank #(.IDX_W(IDX_W), .VAL_W(VAL_W), .CH(NUM_CH)) bank_i (
            .clk(clk), .we(bank_we), .waddr(wr_idx), .wdata(wr_val),
            .raddr(pix_in), .rdata(rdata[b])
        );
    end

    igam_live_ctrl live_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .mode_req(mode_req), .live(live), .status(live_status)
    );

    igam_pix_path #(.IDX_W(IDX_W), .VAL_W(VAL_W)) pix_i (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_in(pix_in),
        .live(live), .rdata_a(rdata[0]), .rdata_b(rdata[1]),
        .out_valid(out_valid), .out_px(out_px)
    );

    assign out_r = out_px[0*VAL_W +: VAL_W];
    assign out_g = out_px[1*VAL_W +: VAL_W];
    assign out_b = out_px[2*VAL_W +: VAL_W];
endmodule

// File: rtl/igam_lut_chk.sv
module igam_lut_chk #(
    parameter int IDX_W = 8,
    parameter int VAL_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_valid,
    input logic [1:0]       host_addr,
    input logic             frame_start,
    input logic             pix_valid,
    input logic [IDX_W-1:0] pix_r,
    input logic             out_valid,
    input logic [VAL_W-1:0] out_r,
    input logic [2:0]       live_status,
    input logic [1:0]       mode_req,
    input logic             pwr_en,
    input logic [1:0]       wr_phase,
    input logic [IDX_W-1:0] wr_idx
);
    localparam int EXT_W = VAL_W - IDX_W;

    AST_VALID_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid); // R2
    AST_VALID_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid); // R2
    AST_BYPASS_WIDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && live_status == 3'd0) |=>
            out_r == {$past(pix_r), $past(pix_r[IDX_W-1 -: EXT_W])}); // R2
    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        live_status <= 3'd2); // R10
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(live_status)); // R9
    AST_FRAME_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && mode_req == 2'd2) |=> live_status == 3'd1); // R9
    AST_FRAME_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && mode_req == 2'd3) |=> live_status == 3'd2); // R9
    AST_INDEX_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_addr == 2'd1) |=> wr_phase == 2'd0); // R7
    AST_PWR_OFF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_addr == 2'd2 && !pwr_en) |=>
            ($stable(wr_phase) && $stable(wr_idx))); // R11
endmodule

bind igam_lut_top igam_lut_chk #(.IDX_W(IDX_W), .VAL_W(VAL_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_addr(host_addr),
    .frame_start(frame_start), .pix_valid(pix_valid), .pix_r(pix_r),
    .out_valid(out_valid), .out_r(out_r), .live_status(live_status),
    .mode_req(mode_req), .pwr_en(pwr_en), .wr_phase(wr_phase), .wr_idx(wr_idx)
);

// File: tb/igam_lut_top_tb_top.sv
`timescale 1ns/1ps
module igam_lut_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic [1:0]  host_addr = '0;
    logic [11:0] host_wdata = '0;
    logic        frame_start = 1'b0;
    logic        pix_valid = 1'b0;
    logic [7:0]  pix_r = '0, pix_g = '0, pix_b = '0;
    logic        out_valid;
    logic [11:0] out_r, out_g, out_b;
    logic [2:0]  live_status;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int mA [256][3];
    int mB [256][3];

    always #4 clk = ~clk;

    igam_lut_top dut_i (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_addr(host_addr),
        .host_wdata(host_wdata), .frame_start(frame_start), .pix_valid(pix_valid),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .out_valid(out_valid),
        .out_r(out_r), .out_g(out_g), .out_b(out_b), .live_status(live_status)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic ck(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int ctrlv(int mode, int bank, int mask, int pwr);
        return mode | (bank << 2) | (mask << 3) | (pwr << 6);
    endfunction

    function automatic int fa(int i, int c);
        return (i * 37 + c * 1301 + 5) % 4096;
    endfunction

    function automatic int fb(int i, int c);
        return (4095 - i * 13 - c * 211 + 8192) % 4096;
    endfunction

    task automatic hw(input int a, input int d);
        @(negedge clk);
        host_valid = 1'b1; host_addr = a[1:0]; host_wdata = d[11:0];
        @(negedge clk);
        host_valid = 1'b0;
    endtask

    task automatic frame();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    // One pixel in; outputs sampled at the next falling edge
    task automatic px(input int r, input int g, input int b);
        @(negedge clk);
        pix_valid = 1'b1; pix_r = r[7:0]; pix_g = g[7:0]; pix_b = b[7:0];
        @(negedge clk);
        pix_valid = 1'b0;
    endtask

    task automatic chk_lut(input string tag, input bit useB, input int r, input int g, input int b);
        px(r, g, b);
        ck({tag, " valid"}, out_valid, 1);
        ck({tag, " red"},   out_r, useB ? mB[r][0] : mA[r][0]);
        ck({tag, " green"}, out_g, useB ? mB[g][1] : mA[g][1]);
        ck({tag, " blue"},  out_b, useB ? mB[b][2] : mA[b][2]);
    endtask

    task automatic chk_byp(input string tag, input int v);
        px(v, 255 - v, v ^ 8'h5a);
        ck({tag, " red"},   out_r, (v << 4) | (v >> 4));
        ck({tag, " green"}, out_g, ((255 - v) << 4) | ((255 - v) >> 4));
        ck({tag, " blue"},  out_b, (((v ^ 8'h5a) & 255) << 4) | (((v ^ 8'h5a) & 255) >> 4));
    endtask

    task automatic data(input bit useB, input int idx, input int ch, input int v);
        hw(2, v);
        if (useB) mB[idx][ch] = v; else mA[idx][ch] = v;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        ck("R1 out_valid", out_valid, 0);
        ck("R1 status", live_status, 0);
        rst_n = 1'b1;
        @(negedge clk);
        ck("R1 status after", live_status, 0);

        // R2: bypass sweep over every code
        for (int v = 0; v < 256; v++) chk_byp("R2 bypass", v);
        @(negedge clk);
        ck("R2 valid drops", out_valid, 0);

        // R4 R5 R8: fill bank A
        hw(0, ctrlv(0, 0, 7, 1));
        hw(1, 0);
        for (int i = 0; i < 256; i++)
            for (int c = 0; c < 3; c++) data(0, i, c, fa(i, c));
        hw(3, 12'hfff);  // R4: address 3 has no effect

        // R9: request bank A, nothing changes before the frame pulse
        hw(0, ctrlv(2, 0, 7, 1));
        ck("R9 status before frame", live_status, 0);
        chk_byp("R9 still bypass", 100);
        frame();
        ck("R10 status A", live_status, 1);
        for (int v = 0; v < 256; v++) chk_lut("R3 bank A", 0, v, (v + 85) % 256, (v * 3) % 256);

        // R8: fill bank B while A is live; A output undisturbed
        hw(0, ctrlv(2, 1, 7, 1));
        hw(1, 0);
        for (int i = 0; i < 256; i++)
            for (int c = 0; c < 3; c++) data(1, i, c, fb(i, c));
        for (int v = 0; v < 256; v += 17) chk_lut("R8 A unchanged", 0, v, 255 - v, v);
        hw(0, ctrlv(3, 1, 7, 1));
        ck("R9 status holds A", live_status, 1);
        frame();
        ck("R10 status B", live_status, 2);
        for (int v = 0; v < 256; v++) chk_lut("R3 bank B", 1, v, (v + 85) % 256, (v * 3) % 256);

        // R6: green-only mask into bank A at index 10; phase still advances
        hw(0, ctrlv(3, 0, 2, 1));
        hw(1, 10);
        hw(2, 12'h111); data(0, 10, 1, 12'h222); hw(2, 12'h333);
        hw(2, 12'h444); data(0, 11, 1, 12'h555); hw(2, 12'h666);

        // R11: memory disabled, data writes ignored entirely
        hw(0, ctrlv(3, 0, 7, 0));
        hw(1, 30);
        hw(2, 12'h0ab); hw(2, 12'h0cd);
        hw(0, ctrlv(3, 0, 7, 1));
        data(0, 30, 0, 12'h7e1);

        hw(0, ctrlv(2, 0, 7, 1));
        frame();
        ck("R9 status back to A", live_status, 1);
        chk_lut("R6 masked idx10", 0, 10, 10, 10);
        chk_lut("R6 masked idx11", 0, 11, 11, 11);
        chk_lut("R11 pwr off idx30", 0, 30, 30, 30);
        chk_lut("R11 idx31 untouched", 0, 31, 31, 31);

        // R7: index rewrite mid-triplet; R5: wrap 255 to 0 (bank B, idle)
        hw(0, ctrlv(2, 1, 7, 1));
        hw(1, 20);
        data(1, 20, 0, 12'h9a0);
        hw(1, 20);
        data(1, 20, 0, 12'h123); data(1, 20, 1, 12'h456); data(1, 20, 2, 12'h789);
        hw(1, 255);
        data(1, 255, 0, 12'hf01); data(1, 255, 1, 12'hf02); data(1, 255, 2, 12'hf03);
        data(1, 0, 0, 12'hf04);
        chk_lut("R8 A live during B update", 0, 20, 255, 0);
        hw(0, ctrlv(3, 1, 7, 1));
        frame();
        chk_lut("R7 index rewrite", 1, 20, 20, 20);
        chk_lut("R5 last index", 1, 255, 255, 255);
        chk_lut("R5 wrap to 0", 1, 0, 0, 0);
        chk_lut("R5 idx21 untouched", 1, 21, 21, 21);

        // R9: mode 1 selects bypass
        hw(0, ctrlv(1, 0, 7, 1));
        frame();
        ck("R10 status bypass", live_status, 0);
        for (int v = 0; v < 256; v += 5) chk_byp("R9 mode1 bypass", v);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule